// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers a bank of hardware interrupt lines and chooses one of them to hand to a processor. The lowest-numbered lines are non-maskable. The remaining lines are collected into fixed groups of consecutive lines, and each group carries a 2-bit priority level. A level of zero switches off every line in the group. Each line passes through a synchroniser and an edge detector. A rising edge marks the line as active. The line stays active, and keeps requesting, until software writes a 1 to its bit.

A byte-wide register port holds three kinds of register: the packed group priorities, the per-line enable bits and the per-line active bits. The processor supplies its interrupt-disable and interrupt-branch flags. The block registers its choice and presents a request, the winning line number and the byte address of that line's 16-bit vector. When the processor acknowledges a request that is being presented, the block pulses an output that sets the processor's interrupt-branch flag.

Top module: `irq_group_ctrl`

## Requirements
- R1: After reset, every priority, enable and active register reads 0, and the request, the branch-set pulse, the line number and the vector are all 0.
- R2: A 0-to-1 transition on a source line sets its active bit. An input that stays high does not set the bit again after it has been cleared. An active bit never drops unless software clears it.
- R3: Writing an active register clears each bit that is written as 1. Bits written as 0 stay unchanged.
- R4: If a rising edge and a write-1 clear reach the same bit in the same cycle, the bit ends up set.
- R5: Line n (n >= 3) belongs to group (n-3)/4. The 2-bit field of group g is at bits [2*(g%4)+1 : 2*(g%4)] of priority register g/4, which is at address 0 or 1. A group whose field is 0 never dispatches.
- R6: A maskable line dispatches only when its enable bit is 1. Line 8k+b has its enable bit at bit b of the register at address 2+k.
- R7: While the interrupt-disable input or the interrupt-branch input is high, no maskable line dispatches. Lines 0 to 2 dispatch whenever they are active, whatever their enables, priorities and flags.
- R8: Any active non-maskable line wins over every maskable line. Among maskable lines, the highest group level wins. Between lines at the same level, the lower line number wins.
- R9: The vector output equals twice the winning line number.
- R10: The request and the line number are registered. They reflect the active, enable, priority and flag state of the previous cycle.
- R11: If the acknowledge input is high while a request is presented, the branch-set output is high for exactly the next cycle.
- R12: Line 8k+b has its active bit at bit b of the register at address 6+k. Reads return the stored state with no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | 32 | Raw interrupt source lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 4 | Write address |
| reg_wdata_i | input | 8 | Write data |
| reg_raddr_i | input | 4 | Read address |
| reg_rdata_o | output | 8 | Read data (combinational) |
| cpu_idis_i | input | 1 | Processor interrupt-disable flag |
| cpu_ibr_i | input | 1 | Processor interrupt-branch flag |
| irq_ack_i | input | 1 | Processor takes the presented interrupt |
| irq_req_o | output | 1 | Interrupt request |
| irq_id_o | output | 5 | Winning line number |
| irq_vec_o | output | 6 | Vector byte address of the winner |
| ibr_set_o | output | 1 | One-cycle pulse that sets the processor branch flag |

## Verification
The assertions assume that the flag inputs and the acknowledge input are synchronous to the clock and held steady across each edge. They also assume that source lines are either synchronous or slow enough for the two-flop synchroniser. The stimulus changes every input only on the falling edge. Source pulses last at least one full cycle, so every pulse produces exactly one edge. Acknowledges are raised only while a request is being presented.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    localparam int DATA_W        = 8;
    localparam int LVL_W         = 3;
    localparam int GRP_PER_REG   = 4;
    localparam int LINES_PER_REG = 8;
    localparam logic [LVL_W-1:0] NMI_LVL = 3'd4;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter int W    = 32,
    parameter int SYNC = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o
);
    typedef struct packed {
        logic [SYNC-1:0][W-1:0] sync;
        logic [W-1:0]           prev;
        logic [W-1:0]           pend;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [W-1:0] rise;

    always_comb begin
        cap_d         = cap_q;
        cap_d.sync[0] = src_i;
        for (int i = 1; i < SYNC; i++) begin
            cap_d.sync[i] = cap_q.sync[i-1];
        end
        rise       = cap_q.sync[SYNC-1] & ~cap_q.prev;
        cap_d.prev = cap_q.sync[SYNC-1];
        // a new edge beats a clear in the same cycle
        cap_d.pend = (cap_q.pend & ~clr_i) | rise;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cap_q <= '0;
        else         cap_q <= cap_d;
    end

    assign pend_o = cap_q.pend;

    // R2
    pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((($past(cap_q.pend) & ~$past(clr_i)) & ~cap_q.pend) == '0));

    // R4
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(rise & clr_i)) |=> ((pend_o & $past(rise & clr_i)) == $past(rise & clr_i)));
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int NUM_NMI   = 3,
    parameter int GRP_LINES = 4,
    parameter int NUM_GROUPS = (NUM_LINES - NUM_NMI + GRP_LINES - 1) / GRP_LINES,
    localparam int ID_W = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]         pend_i,
    input  logic [NUM_LINES-1:NUM_NMI]   ena_i,
    input  logic [2*NUM_GROUPS-1:0]      pri_i,
    input  logic                         mask_all_i,
    output logic                         win_valid_o,
    output logic [ID_W-1:0]              win_id_o
);
    logic [LVL_W-1:0] lvl [NUM_LINES];
    logic [LVL_W-1:0] best_lvl;
    logic [ID_W-1:0]  best_id;

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_lvl
        if (n < NUM_NMI) begin : g_nmi
            assign lvl[n] = pend_i[n] ? NMI_LVL : '0;
        end else begin : g_mask
            localparam int GRP = (n - NUM_NMI) / GRP_LINES;
            assign lvl[n] = (pend_i[n] && ena_i[n] && !mask_all_i)
                          ? {1'b0, pri_i[2*GRP +: 2]} : '0;
        end
    end

    // scan from the top so that ties settle on the lowest number
    always_comb begin
        best_lvl = '0;
        best_id  = '0;
        for (int n = NUM_LINES - 1; n >= 0; n--) begin
            if (lvl[n] != '0 && lvl[n] >= best_lvl) begin
                best_lvl = lvl[n];
                best_id  = ID_W'(n);
            end
        end
    end

    assign win_valid_o = (best_lvl != '0);
    assign win_id_o    = best_id;
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int NUM_NMI   = 3,
    parameter int GRP_LINES = 4,
    parameter int ADDR_W    = 4
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [NUM_LINES-1:0]         irq_src_i,
    input  logic                         reg_we_i,
    input  logic [ADDR_W-1:0]            reg_waddr_i,
    input  logic [DATA_W-1:0]            reg_wdata_i,
    input  logic [ADDR_W-1:0]            reg_raddr_i,
    output logic [DATA_W-1:0]            reg_rdata_o,
    input  logic                         cpu_idis_i,
    input  logic                         cpu_ibr_i,
    input  logic                         irq_ack_i,
    output logic                         irq_req_o,
    output logic [$clog2(NUM_LINES)-1:0] irq_id_o,
    output logic [$clog2(NUM_LINES):0]   irq_vec_o,
    output logic                         ibr_set_o
);
    localparam int ID_W       = $clog2(NUM_LINES);
    localparam int NUM_GROUPS = (NUM_LINES - NUM_NMI + GRP_LINES - 1) / GRP_LINES;
    localparam int PRI_REGS   = (NUM_GROUPS + GRP_PER_REG - 1) / GRP_PER_REG;
    localparam int LINE_REGS  = (NUM_LINES + LINES_PER_REG - 1) / LINES_PER_REG;
    localparam int ENA_BASE   = PRI_REGS;
    localparam int ACT_BASE   = PRI_REGS + LINE_REGS;

    typedef struct packed {
        logic [2*NUM_GROUPS-1:0] pri;
        logic [NUM_LINES-1:0]    ena;
        logic                    req;
        logic [ID_W-1:0]         id;
        logic                    ibr_set;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [NUM_LINES-1:0] clr_mask;
    logic [NUM_LINES-1:0] pend;
    logic                 win_valid;
    logic [ID_W-1:0]      win_id;
    int                   wa, ra;

    irq_edge_latch #(.W(NUM_LINES), .SYNC(2)) u_latch (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (irq_src_i),
        .clr_i  (clr_mask),
        .pend_o (pend)
    );

    irq_pick #(
        .NUM_LINES (NUM_LINES),
        .NUM_NMI   (NUM_NMI),
        .GRP_LINES (GRP_LINES),
        .NUM_GROUPS(NUM_GROUPS)
    ) u_pick (
        .pend_i      (pend),
        .ena_i       (ctl_q.ena[NUM_LINES-1:NUM_NMI]),
        .pri_i       (ctl_q.pri),
        .mask_all_i  (cpu_idis_i | cpu_ibr_i),
        .win_valid_o (win_valid),
        .win_id_o    (win_id)
    );

    always_comb begin
        ctl_d    = ctl_q;
        clr_mask = '0;
        wa       = int'(reg_waddr_i);
        if (reg_we_i) begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (wa == g / GRP_PER_REG)
                    ctl_d.pri[2*g +: 2] = reg_wdata_i[2*(g % GRP_PER_REG) +: 2];
            end
            for (int n = 0; n < NUM_LINES; n++) begin
                if (wa == ENA_BASE + n / LINES_PER_REG)
                    ctl_d.ena[n] = reg_wdata_i[n % LINES_PER_REG];
                if (wa == ACT_BASE + n / LINES_PER_REG)
                    clr_mask[n] = reg_wdata_i[n % LINES_PER_REG];
            end
        end
        ctl_d.req     = win_valid;
        ctl_d.id      = win_id;
        ctl_d.ibr_set = irq_ack_i & ctl_q.req;
    end

    always_comb begin
        reg_rdata_o = '0;
        ra          = int'(reg_raddr_i);
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (ra == g / GRP_PER_REG)
                reg_rdata_o[2*(g % GRP_PER_REG) +: 2] = ctl_q.pri[2*g +: 2];
        end
        for (int n = 0; n < NUM_LINES; n++) begin
            if (ra == ENA_BASE + n / LINES_PER_REG)
                reg_rdata_o[n % LINES_PER_REG] = ctl_q.ena[n];
            if (ra == ACT_BASE + n / LINES_PER_REG)
                reg_rdata_o[n % LINES_PER_REG] = pend[n];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    assign irq_req_o = ctl_q.req;
    assign irq_id_o  = ctl_q.id;
    assign irq_vec_o = {ctl_q.id, 1'b0};
    assign ibr_set_o = ctl_q.ibr_set;

    // R7
    mask_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_valid && int'(win_id) >= NUM_NMI) |-> !(cpu_idis_i || cpu_ibr_i));

    // R8
    win_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_valid |-> pend[win_id]);

    // R10
    req_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend == '0) |=> !irq_req_o);

    // R11
    ibr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ibr_set_o |-> $past(irq_ack_i && irq_req_o));
endmodule

// File: tb/irq_group_ctrl_bench.sv
module irq_group_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        we = 1'b0;
    logic [3:0]  waddr = '0;
    logic [7:0]  wdata = '0;
    logic [3:0]  raddr = '0;
    logic [7:0]  rdata;
    logic        idis = 1'b0, ibr = 1'b0, ack = 1'b0;
    logic        req;
    logic [4:0]  id;
    logic [5:0]  vec;
    logic        bset;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_pend = '0;
    logic [31:0] m_ena  = '0;
    logic [7:0]  m_pri [2];

    always #10 clk = ~clk;

    irq_group_ctrl u_irq_group_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src),
        .reg_we_i(we), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
        .reg_raddr_i(raddr), .reg_rdata_o(rdata),
        .cpu_idis_i(idis), .cpu_ibr_i(ibr), .irq_ack_i(ack),
        .irq_req_o(req), .irq_id_o(id), .irq_vec_o(vec), .ibr_set_o(bset)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; waddr = 4'(a); wdata = d;
        @(negedge clk);
        we = 1'b0;
        if (a < 2) m_pri[a] = d;
        else if (a < 6) m_ena[8*(a-2) +: 8] = d;
        else if (a < 10) m_pend[8*(a-6) +: 8] &= ~d;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        raddr = 4'(a);
        #1 d = rdata;
    endtask

    task automatic pulse(input logic [31:0] m);
        @(negedge clk); src = m;
        @(negedge clk); src = '0;
        m_pend |= m;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        for (int a = 6; a < 10; a++) wr(a, 8'hFF);
    endtask

    // expected winner from the requirement text: {valid, id}
    function automatic logic [5:0] model();
        int best_l = 0;
        int best_n = 0;
        for (int n = 31; n >= 0; n--) begin
            int l = 0;
            if (m_pend[n]) begin
                if (n < 3) l = 4;
                else if (m_ena[n] && !idis && !ibr) begin
                    int g = (n - 3) / 4;
                    l = int'(m_pri[g/4][2*(g%4) +: 2]);
                end
            end
            if (l != 0 && l >= best_l) begin best_l = l; best_n = n; end
        end
        return {best_l != 0, 5'(best_n)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [5:0] e;
        m_pri[0] = '0; m_pri[1] = '0;
        settle(3);
        rst_n = 1'b1;
        settle(2);

        // R1 reset state
        for (int a = 0; a < 10; a++) begin
            rd(a, d);
            chk($sformatf("R1 reg %0d", a), d, 0);
        end
        chk("R1 req", req, 0);
        chk("R1 id", id, 0);
        chk("R1 vec", vec, 0);
        chk("R1 bset", bset, 0);

        // R10 exact latency of an enable change
        wr(0, 8'h55); wr(1, 8'h55);
        pulse(32'h1 << 9);
        settle(5);
        chk("R6 disabled line idle", req, 0);
        wr(3, 8'h02);                       // enable line 9
        chk("R10 req one cycle later (before)", req, 0);
        settle(1);
        chk("R10 req one cycle later (after)", req, 1);
        chk("R10 id", id, 9);
        clear_all();

        // sweep every line on its own
        for (int a = 2; a < 6; a++) wr(a, 8'hFF);
        for (int n = 0; n < 32; n++) begin
            pulse(32'h1 << n);
            settle(5);
            chk($sformatf("R2 req line %0d", n), req, 1);
            chk($sformatf("R9 id line %0d", n), id, n);
            chk($sformatf("R9 vec line %0d", n), vec, 2*n);
            rd(6 + n/8, d);
            chk($sformatf("R12 act bit line %0d", n), d, 8'h1 << (n%8));
            wr(6 + n/8, 8'h00);
            rd(6 + n/8, d);
            chk($sformatf("R3 write0 keeps line %0d", n), d, 8'h1 << (n%8));
            wr(6 + n/8, 8'h1 << (n%8));
            settle(1);
            chk($sformatf("R3 cleared line %0d", n), req, 0);
        end

        // R5 priority zero silences a group; R7 NMI ignores everything
        wr(0, 8'h54);                       // group 0 level 0
        pulse(32'h1 << 4);
        settle(5);
        chk("R5 zero level group", req, 0);
        idis = 1'b1;
        wr(2, 8'h00);
        pulse(32'h1 << 2);
        settle(5);
        chk("R7 NMI under disable", req, 1);
        chk("R7 NMI id", id, 2);
        idis = 1'b0;
        clear_all();
        wr(2, 8'hFF);

        // R8 tie in one group: lower wins; R11 ack pulse
        wr(0, 8'h55);
        pulse((32'h1 << 6) | (32'h1 << 5));
        settle(5);
        chk("R8 tie lower wins", id, 5);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        chk("R11 branch pulse high", bset, 1);
        settle(1);
        chk("R11 branch pulse ends", bset, 0);
        clear_all();

        // R4 edge and clear in the same cycle; R2 held high no retrigger
        pulse(32'h1 << 5);
        settle(3);
        @(negedge clk); src[5] = 1'b1;
        @(negedge clk);
        @(negedge clk); we = 1'b1; waddr = 4'd6; wdata = 8'h20;
        @(negedge clk); we = 1'b0;
        rd(6, d);
        chk("R4 set wins over clear", d[5], 1);
        wr(6, 8'h20);
        settle(4);
        rd(6, d);
        chk("R2 held input no retrigger", d[5], 0);
        @(negedge clk); src = '0;
        settle(3);

        // priority / enable / flag / pattern sweep
        for (int c = 0; c < 40; c++) begin
            logic [31:0] pat;
            clear_all();
            pat = (32'h9E3779B9 * (c + 1)) ^ (32'h1 << (c % 32));
            if (c % 6 != 0) pat &= ~32'h7;
            wr(0, 8'(c * 37 + 11));
            wr(1, 8'(c * 53 + 5));
            for (int a = 2; a < 6; a++) wr(a, 8'(~(pat >> (a + c))));
            idis = (c % 5 == 0);
            ibr  = (c % 7 == 3);
            pulse(pat);
            settle(5);
            e = model();
            chk($sformatf("R8 R5 R6 R7 req cfg %0d", c), req, e[5]);
            if (e[5]) chk($sformatf("R8 id cfg %0d", c), id, e[4:0]);
            idis = 1'b0; ibr = 1'b0;
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule